// File: doc/BRIEF.md
# Pulse-Width Infrared Frame Decoder

This block recovers a data byte from an infrared remote-style link in which each symbol is a burst of carrier (a mark) followed by a gap (a space), and the symbol value is carried by the mark length. It watches the demodulated, active-low receiver output once per sample tick, with a nominal tick rate of 80 kHz. It measures every mark and every space in ticks. A frame is a long start mark followed by twelve data marks. The first eight data marks received form the byte and the last four are dropped.

The decoder sorts each mark into one of four classes by comparing its length with fixed thresholds: start, one, zero or too short. A start mark may arrive at any point in a frame, and it restarts the frame. A mark that is too short abandons the frame. A space that runs too long also abandons it, unless the twelfth bit has already been taken. In that case the long space is the normal end of the frame. A finished frame places the byte on `data_o` and raises `valid_o` for one clock.

After reset the block waits for a settling period before it listens to the line. While `enable_i` is low the decoder stays idle, so a nearby transmitter cannot feed its own bursts back into the decoder.

Top module: `irpw_frame_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` is 0 and `data_o` is 0.
- R2: After reset the line is ignored for SETTLE_TICKS ticks (default 40000). A complete frame sent in that window produces no output.
- R3: Mark length is the number of consecutive ticks on which `ir_n_i` was sampled low. A mark of 90 to 185 ticks is a 1 and a mark of 42 to 89 ticks is a 0. `ir_n_i` is only sampled in cycles where `tick_i` is high.
- R4: A mark of 186 ticks or more, including marks long enough to saturate the counter, is a start symbol. At any point in a frame it discards the bits gathered so far and restarts the count of twelve.
- R5: A mark shorter than 42 ticks abandons the frame without output. The decoder then waits in idle for the next low level.
- R6: The first data bit received after the start lands in `data_o[0]`, and the eighth lands in `data_o[7]`. Data bits nine to twelve do not affect `data_o`.
- R7: A space that reaches 54 high ticks before twelve bits have been taken abandons the frame without output. A space of 53 ticks is accepted.
- R8: Once twelve bits are taken, the frame completes on the first tick that the following space ends. The space ends either when the line is sampled low again or when it reaches 54 ticks. `valid_o` is then high for exactly one clock, and `data_o` holds the byte until the next completed frame.
- R9: While `enable_i` is low, any frame in progress is dropped, the decoder stays idle and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock sample strobe, nominally 80 kHz |
| enable_i | input | 1 | High to listen. Low forces idle. |
| ir_n_i | input | 1 | Demodulated receiver output, low while carrier is present, synchronous to clk |
| data_o | output | 8 | Last decoded byte |
| valid_o | output | 1 | One-clock strobe when a frame completes |

## Verification
Nominal frames with different bytes and address nibbles show the bit order and show that the address bits are dropped. A frame built from marks sitting exactly on each threshold, with every space at 53 ticks, separates a correct boundary compare from an off-by-one. That frame ends on a new low level, so it also exercises the second way a frame can complete. Broken frames are built so that a decoder missing the short-mark check, the space watchdog or the resynchronising start would still gather twelve bits and emit a byte; a correct decoder emits nothing. Frames sent during settling, with enable low, and with an over-long start mark check the remaining gating paths.

// File: rtl/irpw_pkg.sv
// Shared types for the pulse-width infrared frame decoder.
package irpw_pkg;

    // Decoder control states.
    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_IDLE,
        ST_MARK,
        ST_SPACE
    } dec_state_t;

    // Classification of a finished mark.
    typedef enum logic [1:0] {
        SYM_ERR,
        SYM_ZERO,
        SYM_ONE,
        SYM_START
    } sym_t;

endpackage

// File: rtl/irpw_len_counter.sv
// Saturating tick counter used to measure line phases.
// restart_i loads 1, so the sample that opens a new phase is counted.
// step_i adds one and sticks at all ones.
// Assumes restart_i and step_i are never high together.
module irpw_len_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         step_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    // Count register: load, step with saturation, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (restart_i) begin
            count_o <= W'(1);
        end else if (step_i && count_o != CNT_MAX) begin
            count_o <= count_o + W'(1);
        end
    end

    // A full count must stay full while it is stepped (long start marks).
    assert_len_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && step_i && !restart_i) |=> count_o == CNT_MAX);

endmodule

// File: rtl/irpw_mark_classifier.sv
// Combinational sort of a mark length into start, one, zero or error.
// Assumes START_MIN > ONE_MIN > ZERO_MIN, and that all three fit in W bits.
module irpw_mark_classifier
    import irpw_pkg::*;
#(
    parameter int W         = 8,
    parameter int START_MIN = 186,
    parameter int ONE_MIN   = 90,
    parameter int ZERO_MIN  = 42
) (
    input  logic [W-1:0] len_i,
    output sym_t         sym_o
);

    localparam logic [W-1:0] START_L = W'(START_MIN);
    localparam logic [W-1:0] ONE_L   = W'(ONE_MIN);
    localparam logic [W-1:0] ZERO_L  = W'(ZERO_MIN);

    // Threshold ladder, longest class first.
    always_comb begin
        if (len_i >= START_L)     sym_o = SYM_START;
        else if (len_i >= ONE_L)  sym_o = SYM_ONE;
        else if (len_i >= ZERO_L) sym_o = SYM_ZERO;
        else                      sym_o = SYM_ERR;
    end

endmodule

// File: rtl/irpw_bit_shifter.sv
// Frame bit store. New bits enter at the top and move toward bit 0.
// It also counts the bits taken since the last clear.
// Assumes push_i is not raised again once full_o is high.
module irpw_bit_shifter #(
    parameter int FRAME_BITS = 12,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);

    localparam int BIT_W = $clog2(FRAME_BITS + 1);
    localparam logic [BIT_W-1:0] FULL_CNT = BIT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [BIT_W-1:0]      taken;

    // Shift register: clear on start or new frame, else shift right on push.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            shreg <= '0;
        end else if (push_i) begin
            shreg <= {bit_i, shreg[FRAME_BITS-1:1]};
        end
    end

    // Bit counter that tracks how much of the frame has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            taken <= '0;
        end else if (push_i) begin
            taken <= taken + BIT_W'(1);
        end
    end

    assign data_o = shreg[DATA_W-1:0];
    assign full_o = (taken == FULL_CNT);

    // The bit count never passes the frame length.
    assert_bits_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        taken <= FULL_CNT);

    // A start symbol or a new frame empties the store.
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !push_i) |=> (taken == '0 && data_o == '0));

endmodule

// File: rtl/irpw_frame_decoder.sv
// Pulse-width infrared frame decoder (top).
// It samples the active-low receiver output on each tick and measures marks
// and spaces. Each mark is classified. A data byte is emitted with a
// one-clock strobe once a twelve-bit frame ends.
// Assumes ir_n_i is already synchronous to clk and tick_i is one clock wide.
module irpw_frame_decoder
    import irpw_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int START_MIN    = 186,
    parameter int ONE_MIN      = 90,
    parameter int ZERO_MIN     = 42,
    parameter int SPACE_LIMIT  = 54,
    parameter int FRAME_BITS   = 12,
    parameter int DATA_W       = 8,
    parameter int SETTLE_TICKS = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              enable_i,
    input  logic              ir_n_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0]    SPACE_LAST  = CNT_W'(SPACE_LIMIT - 1);
    localparam logic [CNT_W-1:0]    SPACE_LIM_L = CNT_W'(SPACE_LIMIT);

    dec_state_t          state, state_nxt;
    sym_t                sym;
    logic                line_low;
    logic [CNT_W-1:0]    len_cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                len_restart, len_step, settle_step;
    logic                sh_clear, sh_push, sh_bit, sh_full;
    logic [DATA_W-1:0]   sh_data;
    logic                frame_done;

    assign line_low = !ir_n_i;

    // Phase length counter shared by marks and spaces.
    irpw_len_counter #(.W(CNT_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (len_restart),
        .step_i    (len_step),
        .count_o   (len_cnt)
    );

    // Power-up settling counter, reusing the same counter.
    irpw_len_counter #(.W(SETTLE_W)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (1'b0),
        .step_i    (settle_step),
        .count_o   (settle_cnt)
    );

    irpw_mark_classifier #(
        .W         (CNT_W),
        .START_MIN (START_MIN),
        .ONE_MIN   (ONE_MIN),
        .ZERO_MIN  (ZERO_MIN)
    ) u_class (
        .len_i (len_cnt),
        .sym_o (sym)
    );

    irpw_bit_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_W     (DATA_W)
    ) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sh_clear),
        .push_i  (sh_push),
        .bit_i   (sh_bit),
        .data_o  (sh_data),
        .full_o  (sh_full)
    );

    // Next-state and datapath control, acting only on tick cycles.
    always_comb begin
        state_nxt   = state;
        len_restart = 1'b0;
        len_step    = 1'b0;
        settle_step = 1'b0;
        sh_clear    = 1'b0;
        sh_push     = 1'b0;
        sh_bit      = 1'b0;
        frame_done  = 1'b0;
        case (state)
            ST_SETTLE: begin
                if (tick_i) begin
                    settle_step = 1'b1;
                    if (settle_cnt == SETTLE_LAST) state_nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (tick_i && line_low) begin
                    state_nxt   = ST_MARK;
                    len_restart = 1'b1;
                    sh_clear    = 1'b1;
                end
            end
            ST_MARK: begin
                if (tick_i) begin
                    if (line_low) begin
                        len_step = 1'b1;
                    end else begin
                        state_nxt   = ST_SPACE;
                        len_restart = 1'b1;
                        case (sym)
                            SYM_ERR:   state_nxt = ST_IDLE;
                            SYM_START: sh_clear  = 1'b1;
                            SYM_ONE: begin
                                sh_push = 1'b1;
                                sh_bit  = 1'b1;
                            end
                            default:   sh_push   = 1'b1;
                        endcase
                    end
                end
            end
            ST_SPACE: begin
                if (tick_i) begin
                    if (line_low) begin
                        if (sh_full) begin
                            frame_done = 1'b1;
                            state_nxt  = ST_IDLE;
                        end else begin
                            state_nxt   = ST_MARK;
                            len_restart = 1'b1;
                        end
                    end else if (len_cnt >= SPACE_LAST) begin
                        frame_done = sh_full;
                        state_nxt  = ST_IDLE;
                    end else begin
                        len_step = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (!enable_i && state != ST_SETTLE) begin
            state_nxt   = ST_IDLE;
            len_restart = 1'b0;
            len_step    = 1'b0;
            sh_clear    = 1'b0;
            sh_push     = 1'b0;
            frame_done  = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= state_nxt;
    end

    // Output byte and one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= frame_done;
            if (frame_done) data_o <= sh_data;
        end
    end

    assert_no_out_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> !valid_o);

    assert_short_mark_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK && tick_i && enable_i && !line_low && sym == SYM_ERR)
        |=> state == ST_IDLE);

    assert_space_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPACE) |-> (len_cnt < SPACE_LIM_L));

    assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> valid_o);

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && state != ST_SETTLE) |=> (state == ST_IDLE && !valid_o));

endmodule

// File: tb/irpw_frame_decoder_test.sv
module irpw_frame_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2500;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       enable_i = 1'b1;
    logic       ir_n_i = 1'b1;
    logic [7:0] data_o;
    logic       valid_o;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    byte unsigned rx_q[$];

    // Reference model state.
    int  m_state = 0;  // 0 settle, 1 idle, 2 mark, 3 space
    int  m_settle = 0;
    int  m_len = 0;
    bit  m_bits[$];
    bit  m_valid = 1'b0;
    logic [7:0] m_data = 8'h00;

    irpw_frame_decoder #(.SETTLE_TICKS(SETTLE)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .enable_i (enable_i),
        .ir_n_i   (ir_n_i),
        .data_o   (data_o),
        .valid_o  (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick strobe: high on every other clock, changed away from the sampling edge.
    initial forever begin
        @(negedge clk);
        tick_i = ~tick_i;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic model_done();
        m_valid = 1'b1;
        for (int i = 0; i < 8; i++) m_data[i] = m_bits[i];
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_settle = 0; m_len = 0; m_valid = 0; m_data = 0;
            m_bits.delete();
        end else begin
            m_valid = 1'b0;
            if (m_state != 0 && !enable_i) begin
                m_state = 1;
            end else if (tick_i) begin
                case (m_state)
                    0: begin
                        m_settle++;
                        if (m_settle == SETTLE) m_state = 1;
                    end
                    1: if (!ir_n_i) begin
                        m_state = 2; m_len = 1; m_bits.delete();
                    end
                    2: begin
                        if (!ir_n_i) begin
                            if (m_len < 255) m_len++;
                        end else if (m_len < 42) begin
                            m_state = 1;
                        end else begin
                            if (m_len >= 186) m_bits.delete();
                            else m_bits.push_back(m_len >= 90);
                            m_state = 3; m_len = 1;
                        end
                    end
                    default: begin
                        if (!ir_n_i) begin
                            if (m_bits.size() == 12) begin
                                model_done(); m_state = 1;
                            end else begin
                                m_state = 2; m_len = 1;
                            end
                        end else begin
                            m_len++;
                            if (m_len >= 54) begin
                                if (m_bits.size() == 12) model_done();
                                m_state = 1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Compare with the model on every clock and record strobed bytes (R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(valid_o == m_valid, "R8", "valid_o vs model", valid_o, m_valid);
            check(data_o == m_data, "R8", "data_o vs model", data_o, m_data);
            if (valid_o) rx_q.push_back(data_o);
        end
    end

    // Hold a level for n sampled ticks.
    task automatic hold(input logic lvl, input int n);
        ir_n_i = lvl;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (tick_i !== 1'b1) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_body(input logic [7:0] b, input logic [3:0] a);
        logic [11:0] v;
        v = {a, b};
        for (int i = 0; i < 12; i++) begin
            hold(1'b0, v[i] ? 96 : 48);
            hold(1'b1, 48);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic [3:0] a, input int start_len);
        hold(1'b0, start_len);
        hold(1'b1, 48);
        send_body(b, a);
    endtask

    task automatic send_bits(input int n, input logic [11:0] v);
        for (int i = 0; i < n; i++) begin
            hold(1'b0, v[i] ? 96 : 48);
            hold(1'b1, 48);
        end
    endtask

    task automatic expect_one(input string req, input logic [7:0] e);
        check(rx_q.size() == 1, req, "byte count", rx_q.size(), 1);
        if (rx_q.size() >= 1) check(rx_q[0] == e, req, "byte value", rx_q[0], e);
        rx_q.delete();
    endtask

    task automatic expect_none(input string req);
        check(rx_q.size() == 0, req, "byte count", rx_q.size(), 0);
        rx_q.delete();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R8 watchdog: actual hung, expected completion");
            finish_run();
        end
    end

    initial begin
        int thr[12];
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held and in the first cycle after it.
        check(valid_o == 1'b0, "R1", "valid_o in reset", valid_o, 0);
        check(data_o == 8'h00, "R1", "data_o in reset", data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0 && data_o == 8'h00, "R1", "outputs after reset",
              {valid_o, data_o}, 0);

        // R2: a full frame inside the settling window is ignored.
        send_frame(8'h77, 4'h0, 192);
        hold(1'b1, 1000);
        expect_none("R2");

        // R3 R6: nominal frames, address bits dropped.
        send_frame(8'hA5, 4'h0, 192);
        hold(1'b1, 80);
        expect_one("R6", 8'hA5);
        send_frame(8'hA5, 4'hC, 192);
        hold(1'b1, 80);
        expect_one("R6", 8'hA5);
        check(data_o == 8'hA5, "R8", "data held after frame", data_o, 8'hA5);

        // R3 R7 R8: threshold marks, 53-tick spaces, end on a new low level.
        thr = '{42, 90, 89, 185, 42, 120, 60, 90, 48, 48, 48, 48};
        hold(1'b0, 192);
        hold(1'b1, 53);
        for (int i = 0; i < 12; i++) begin
            hold(1'b0, thr[i]);
            hold(1'b1, 53);
        end
        send_frame(8'h3C, 4'h5, 192);
        hold(1'b1, 80);
        check(rx_q.size() == 2, "R3", "threshold byte count", rx_q.size(), 2);
        if (rx_q.size() == 2) begin
            check(rx_q[0] == 8'hAA, "R3", "threshold byte", rx_q[0], 8'hAA);
            check(rx_q[1] == 8'h3C, "R8", "frame after low-ended frame", rx_q[1], 8'h3C);
        end
        rx_q.delete();

        // R5: a 41-tick mark aborts, so the remaining twelve marks give nothing.
        hold(1'b0, 192);
        hold(1'b1, 48);
        send_bits(3, 12'h005);
        hold(1'b0, 41);
        hold(1'b1, 48);
        send_bits(8, 12'h0FF);
        hold(1'b1, 80);
        expect_none("R5");

        // R7: a 54-tick space aborts the frame.
        hold(1'b0, 192);
        hold(1'b1, 48);
        send_bits(4, 12'h00F);
        hold(1'b0, 96);
        hold(1'b1, 54);
        send_bits(7, 12'h07F);
        hold(1'b1, 80);
        expect_none("R7");

        // R4: a start in mid-frame restarts the bit count.
        hold(1'b0, 192);
        hold(1'b1, 48);
        send_bits(6, 12'h03F);
        send_frame(8'h5A, 4'h3, 192);
        hold(1'b1, 80);
        expect_one("R4", 8'h5A);

        // R4: an over-long start mark saturates and still counts as start.
        send_frame(8'hC3, 4'h0, 300);
        hold(1'b1, 80);
        expect_one("R4", 8'hC3);

        // R9: a frame sent with enable low gives nothing, then decodes once enabled.
        enable_i = 1'b0;
        send_frame(8'h99, 4'h0, 192);
        hold(1'b1, 80);
        expect_none("R9");
        enable_i = 1'b1;
        send_frame(8'h99, 4'h0, 192);
        hold(1'b1, 80);
        expect_one("R9", 8'h99);

        // R9: enable dropped mid-frame abandons it.
        hold(1'b0, 192);
        hold(1'b1, 48);
        send_bits(6, 12'h015);
        enable_i = 1'b0;
        hold(1'b1, 10);
        enable_i = 1'b1;
        send_bits(6, 12'h02A);
        hold(1'b1, 80);
        expect_none("R9");

        finish_run();
    end

endmodule